// File: doc/BRIEF.md
# Home Directory Controller with Full Sharer Vector

This block is the home node of a coherence fabric in which caches talk to it over ordered point-to-point links. For every line it holds a stable or transient state, a pointer to the cache that owns the line, a bit vector with one bit per cache marking the read-only holders, and the memory copy of the data. Caches send it four kinds of request: read permission, write permission, a clean eviction and a dirty eviction carrying data. It answers with data messages, forwarded requests to the current owner, invalidations to sharers and eviction acknowledgments.

When a cache asks for write permission on a line that others hold read-only, the directory sends the data straight away with a count of invalidations to expect. It then sends one invalidation per cycle to the other holders, who acknowledge the new owner directly. A read request to a line held modified elsewhere is forwarded to the owner. The line then waits in a transient state until the owner returns its copy on a separate write-back port. Requests to a line in that state are held at the request port, and requests to other lines keep flowing.

Top module: `dir_ctrl`

## Requirements
- R1: After reset, every line has no holders and memory data zero, no message is valid and `req_ready` is high.
- R2: A read request (req_type 0) to a line with no holder, or with only read-only holders, is answered with a data message (msg_type 0) to the requestor carrying the memory value and count 0, and the requestor joins the holders.
- R3: A write request (req_type 1) to a line with no holder is answered with a data message carrying the memory value and count 0, and the requestor becomes owner.
- R4: A write request to a line with read-only holders is answered first with a data message whose count is the number of holders other than the requestor. One invalidation (msg_type 3) follows per cycle to each such holder, lowest cache index first, with msg_req naming the new owner. `req_ready` stays low until the last one is sent.
- R5: A read request to an owned line sends a forwarded read (msg_type 1) to the owner with msg_req naming the requestor. Requests to that line are held with `req_ready` low until the owner's write-back arrives. That data is copied to memory, and owner and requestor become read-only holders.
- R6: A write request to an owned line sends a forwarded write (msg_type 2) to the current owner, and the requestor becomes the new owner.
- R7: A dirty eviction (req_type 3) from the owner writes its data to memory, is acknowledged (msg_type 4) and leaves the line with no holder.
- R8: A dirty eviction from a cache that is not the owner is only acknowledged; memory, owner and state stay unchanged.
- R9: A clean eviction (req_type 2) is acknowledged and removes the requestor from the holders; when the last holder leaves, the line has no holder.
- R10: While one line waits for a write-back, requests to other lines are accepted without delay.
- R11: Write-back data is taken only for a line waiting for it and only from its recorded owner; any other write-back leaves memory unchanged.
- R12: Every accepted request produces exactly one message in the next cycle, at most one message is valid per cycle, and no message appears while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_type | input | 2 | 0 read, 1 write, 2 clean eviction, 3 dirty eviction |
| req_src | input | $clog2(N_CACHES) | Requesting cache |
| req_line | input | $clog2(N_LINES) | Line index |
| req_data | input | DATA_W | Eviction data for a dirty eviction |
| wb_valid | input | 1 | Owner write-back present |
| wb_src | input | $clog2(N_CACHES) | Cache sending the write-back |
| wb_line | input | $clog2(N_LINES) | Line of the write-back |
| wb_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_type | output | 3 | 0 data, 1 fwd read, 2 fwd write, 3 invalidate, 4 eviction ack |
| msg_dest | output | $clog2(N_CACHES) | Destination cache |
| msg_req | output | $clog2(N_CACHES) | Original requestor (forwards, invalidations, acks) |
| msg_line | output | $clog2(N_LINES) | Line index |
| msg_data | output | DATA_W | Data for a data message |
| msg_ackcnt | output | $clog2(N_CACHES+1) | Invalidations the requestor must collect |

## Verification
The checker watches every cycle that each accepted request yields a message next cycle, and that message types stay legal. It also checks that invalidations in a burst climb in cache index and never target the new owner, that the port is busy while invalidations remain, and that read answers never carry a count. Whether the count matches the real holders, whether forwards reach the right owner after ownership moves, and whether memory holds write-back or eviction data depend on history across many requests. Only the bench's scenarios, scored against an expected-message queue, show those.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    LS_I  = 2'd0,
    LS_S  = 2'd1,
    LS_M  = 2'd2,
    LS_SD = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_DROP  = 2'd2,
    RQ_EVICT = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    MK_DATA   = 3'd0,
    MK_FWD_RD = 3'd1,
    MK_FWD_WR = 3'd2,
    MK_INV    = 3'd3,
    MK_ACK    = 3'd4
  } msg_kind_e;
endpackage

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  hit,
  output logic [IW-1:0] idx
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign hit[g]    = vec[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/dir_popcount.sv
module dir_popcount #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 32,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int LINE_W  = $clog2(N_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_W-1:0]   rd_line,
  output line_state_e         rd_state,
  output logic [ID_W-1:0]     rd_owner,
  output logic [N_CACHES-1:0] rd_sharers,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [LINE_W-1:0]   rd2_line,
  output line_state_e         rd2_state,
  output logic [ID_W-1:0]     rd2_owner,
  input  logic                wa_en,
  input  logic [LINE_W-1:0]   wa_line,
  input  line_state_e         wa_state,
  input  logic [ID_W-1:0]     wa_owner,
  input  logic [N_CACHES-1:0] wa_sharers,
  input  logic                wa_data_en,
  input  logic [DATA_W-1:0]   wa_data,
  input  logic                wb_en,
  input  logic [LINE_W-1:0]   wb_line,
  input  logic [DATA_W-1:0]   wb_data
);
  line_state_e         st_q  [N_LINES];
  logic [ID_W-1:0]     own_q [N_LINES];
  logic [N_CACHES-1:0] shr_q [N_LINES];
  logic [DATA_W-1:0]   dat_q [N_LINES];

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_line
      logic sel_a, sel_b, meta_en, dat_en;
      line_state_e         st_d;
      logic [ID_W-1:0]     own_d;
      logic [N_CACHES-1:0] shr_d;
      logic [DATA_W-1:0]   dat_d;

      assign sel_a   = wa_en && (wa_line == LINE_W'(g));
      assign sel_b   = wb_en && (wb_line == LINE_W'(g));
      assign meta_en = sel_a | sel_b;
      assign dat_en  = (sel_a & wa_data_en) | (sel_b & ~sel_a);

      always_comb begin
        st_d  = st_q[g];
        own_d = own_q[g];
        shr_d = shr_q[g];
        dat_d = dat_q[g];
        if (sel_a) begin
          st_d  = wa_state;
          own_d = wa_owner;
          shr_d = wa_sharers;
          dat_d = wa_data;
        end else if (sel_b) begin
          st_d  = LS_S;
          dat_d = wb_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g]  <= LS_I;
          own_q[g] <= '0;
          shr_q[g] <= '0;
        end else if (meta_en) begin
          st_q[g]  <= st_d;
          own_q[g] <= own_d;
          shr_q[g] <= shr_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dat_q[g] <= '0;
        end else if (dat_en) begin
          dat_q[g] <= dat_d;
        end
      end
    end
  endgenerate

  assign rd_state   = st_q[rd_line];
  assign rd_owner   = own_q[rd_line];
  assign rd_sharers = shr_q[rd_line];
  assign rd_data    = dat_q[rd_line];
  assign rd2_state  = st_q[rd2_line];
  assign rd2_owner  = own_q[rd2_line];
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 32,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ID_W-1:0]   req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  input  logic              wb_valid,
  input  logic [ID_W-1:0]   wb_src,
  input  logic [LINE_W-1:0] wb_line,
  input  logic [DATA_W-1:0] wb_data,
  output logic              msg_valid,
  output logic [2:0]        msg_type,
  output logic [ID_W-1:0]   msg_dest,
  output logic [ID_W-1:0]   msg_req,
  output logic [LINE_W-1:0] msg_line,
  output logic [DATA_W-1:0] msg_data,
  output logic [CNT_W-1:0]  msg_ackcnt
);
  localparam logic [N_CACHES-1:0] ONE_HOT0 = N_CACHES'(1);

  // directory read/write
  line_state_e         rd_state, rd2_state, wa_state;
  logic [ID_W-1:0]     rd_owner, rd2_owner, wa_owner;
  logic [N_CACHES-1:0] rd_sharers, wa_sharers;
  logic [DATA_W-1:0]   rd_data;
  logic                wa_en, wa_data_en, wb_take;

  // invalidation burst state
  logic [N_CACHES-1:0] inv_pend_q, inv_pend_d;
  logic [ID_W-1:0]     inv_req_q;
  logic [LINE_W-1:0]   inv_line_q;
  logic                inv_load;
  logic [N_CACHES-1:0] pick_hit;
  logic [ID_W-1:0]     pick_idx;

  // message registers
  logic              mv_q, mv_d;
  msg_kind_e         mt_q, mt_d;
  logic [ID_W-1:0]   md_q, md_d, mr_q, mr_d;
  logic [LINE_W-1:0] ml_q, ml_d;
  logic [DATA_W-1:0] mdat_q, mdat_d;
  logic [CNT_W-1:0]  mc_q, mc_d;
  logic              msg_load;

  logic [N_CACHES-1:0] req_bit, owner_bit, others, left;
  logic [CNT_W-1:0]    other_cnt;
  logic                busy, accept;
  req_kind_e           kind;

  dir_store #(
    .N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_line(req_line), .rd_state(rd_state), .rd_owner(rd_owner),
    .rd_sharers(rd_sharers), .rd_data(rd_data),
    .rd2_line(wb_line), .rd2_state(rd2_state), .rd2_owner(rd2_owner),
    .wa_en(wa_en), .wa_line(req_line), .wa_state(wa_state),
    .wa_owner(wa_owner), .wa_sharers(wa_sharers),
    .wa_data_en(wa_data_en), .wa_data(req_data),
    .wb_en(wb_take), .wb_line(wb_line), .wb_data(wb_data)
  );

  dir_low_pick #(.N(N_CACHES)) u_pick (
    .vec(inv_pend_q), .hit(pick_hit), .idx(pick_idx)
  );

  dir_popcount #(.N(N_CACHES), .CW(CNT_W)) u_cnt (
    .vec(others), .cnt(other_cnt)
  );

  assign kind      = req_kind_e'(req_type);
  assign req_bit   = ONE_HOT0 << req_src;
  assign owner_bit = ONE_HOT0 << rd_owner;
  assign others    = rd_sharers & ~req_bit;
  assign left      = rd_sharers & ~req_bit;
  assign busy      = |inv_pend_q;
  assign req_ready = ~busy & (rd_state != LS_SD);
  assign accept    = req_valid & req_ready;
  assign wb_take   = wb_valid & (rd2_state == LS_SD) & (wb_src == rd2_owner);
  assign inv_load  = accept;
  assign msg_load  = mv_d | mv_q;

  // next-state logic
  always_comb begin
    wa_en      = 1'b0;
    wa_data_en = 1'b0;
    wa_state   = rd_state;
    wa_owner   = rd_owner;
    wa_sharers = rd_sharers;
    inv_pend_d = inv_pend_q;
    mv_d       = 1'b0;
    mt_d       = MK_DATA;
    md_d       = '0;
    mr_d       = '0;
    ml_d       = '0;
    mdat_d     = '0;
    mc_d       = '0;

    if (busy) begin
      mv_d       = 1'b1;
      mt_d       = MK_INV;
      md_d       = pick_idx;
      mr_d       = inv_req_q;
      ml_d       = inv_line_q;
      inv_pend_d = inv_pend_q & ~pick_hit;
    end else if (accept) begin
      mv_d  = 1'b1;
      md_d  = req_src;
      mr_d  = req_src;
      ml_d  = req_line;
      wa_en = 1'b1;
      unique case (kind)
        RQ_READ: begin
          if (rd_state == LS_M) begin
            mt_d       = MK_FWD_RD;
            md_d       = rd_owner;
            wa_state   = LS_SD;
            wa_sharers = req_bit | owner_bit;
          end else begin
            mt_d       = MK_DATA;
            mdat_d     = rd_data;
            wa_state   = LS_S;
            wa_sharers = rd_sharers | req_bit;
          end
        end
        RQ_WRITE: begin
          if (rd_state == LS_M) begin
            mt_d     = MK_FWD_WR;
            md_d     = rd_owner;
            wa_owner = req_src;
          end else begin
            mt_d       = MK_DATA;
            mdat_d     = rd_data;
            wa_state   = LS_M;
            wa_owner   = req_src;
            wa_sharers = '0;
            if (rd_state == LS_S) begin
              mc_d       = other_cnt;
              inv_pend_d = others;
            end
          end
        end
        RQ_DROP: begin
          mt_d = MK_ACK;
          if (rd_state == LS_S) begin
            wa_sharers = left;
            if (left == '0) wa_state = LS_I;
          end
        end
        RQ_EVICT: begin
          mt_d = MK_ACK;
          if ((rd_state == LS_M) && (rd_owner == req_src)) begin
            wa_data_en = 1'b1;
            wa_state   = LS_I;
            wa_owner   = '0;
            wa_sharers = '0;
          end
        end
        default: mt_d = MK_ACK;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_pend_q <= '0;
    end else begin
      inv_pend_q <= inv_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_req_q  <= '0;
      inv_line_q <= '0;
    end else if (inv_load) begin
      inv_req_q  <= req_src;
      inv_line_q <= req_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= 1'b0;
      mt_q   <= MK_DATA;
      md_q   <= '0;
      mr_q   <= '0;
      ml_q   <= '0;
      mdat_q <= '0;
      mc_q   <= '0;
    end else if (msg_load) begin
      mv_q   <= mv_d;
      mt_q   <= mt_d;
      md_q   <= md_d;
      mr_q   <= mr_d;
      ml_q   <= ml_d;
      mdat_q <= mdat_d;
      mc_q   <= mc_d;
    end
  end

  assign msg_valid  = mv_q;
  assign msg_type   = mt_q;
  assign msg_dest   = md_q;
  assign msg_req    = mr_q;
  assign msg_line   = ml_q;
  assign msg_data   = mdat_q;
  assign msg_ackcnt = mc_q;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 32,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_type,
  input logic [ID_W-1:0]   req_src,
  input logic              msg_valid,
  input logic [2:0]        msg_type,
  input logic [ID_W-1:0]   msg_dest,
  input logic [ID_W-1:0]   msg_req,
  input logic [CNT_W-1:0]  msg_ackcnt
);
  a_r12_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> msg_valid);

  a_r12_legal_kind: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_type <= 3'd4));

  a_r4_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd3 && $past(msg_valid) && $past(msg_type) == 3'd3)
      |-> (msg_dest > $past(msg_dest)));

  a_r4_inv_not_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd3) |-> (msg_dest != msg_req));

  a_r4_busy_while_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd0 && msg_ackcnt != '0) |-> !req_ready);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd0) |-> (msg_ackcnt < CNT_W'(N_CACHES)));

  a_r2_read_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd0 && $past(req_valid && req_ready && req_type == 2'd0))
      |-> (msg_ackcnt == '0 && msg_dest == $past(req_src)));
endmodule

bind dir_ctrl dir_ctrl_chk #(
  .N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_type(req_type), .req_src(req_src), .msg_valid(msg_valid),
  .msg_type(msg_type), .msg_dest(msg_dest), .msg_req(msg_req),
  .msg_ackcnt(msg_ackcnt)
);

// File: tb/dir_ctrl_tb.sv
module dir_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int DW = 32;

  localparam int T_DATA = 0, T_FRD = 1, T_FWR = 2, T_INV = 3, T_ACK = 4;
  localparam int Q_RD = 0, Q_WR = 1, Q_DROP = 2, Q_EV = 3;

  logic clk, rst_n;
  logic req_valid, req_ready, wb_valid, msg_valid;
  logic [1:0] req_type;
  logic [1:0] req_src, wb_src, msg_dest, msg_req;
  logic [2:0] req_line, wb_line, msg_line;
  logic [DW-1:0] req_data, wb_data, msg_data;
  logic [2:0] msg_type, msg_ackcnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    int t; int dest; int rq; int line;
    logic [DW-1:0] data; int ack; bit chk_data; string tag;
  } exp_t;
  exp_t expq[$];

  dir_ctrl #(.N_CACHES(NC), .N_LINES(NL), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_line(req_line),
    .req_data(req_data), .wb_valid(wb_valid), .wb_src(wb_src),
    .wb_line(wb_line), .wb_data(wb_data), .msg_valid(msg_valid),
    .msg_type(msg_type), .msg_dest(msg_dest), .msg_req(msg_req),
    .msg_line(msg_line), .msg_data(msg_data), .msg_ackcnt(msg_ackcnt)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_msg(input int t, input int dest, input int rq, input int line,
                            input logic [DW-1:0] data, input int ack, input bit chk,
                            input string tag);
    exp_t e;
    e.t = t; e.dest = dest; e.rq = rq; e.line = line;
    e.data = data; e.ack = ack; e.chk_data = chk; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (expq.size() == 0) begin
        check(0, "R12", "unexpected message type", int'(msg_type), -1);
      end else begin
        exp_t e;
        bit ok;
        e = expq.pop_front();
        ok = (int'(msg_type) == e.t) && (int'(msg_dest) == e.dest) &&
             (int'(msg_req) == e.rq) && (int'(msg_line) == e.line) &&
             (int'(msg_ackcnt) == e.ack) && (!e.chk_data || msg_data == e.data);
        n_tests++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: actual t=%0d d=%0d r=%0d l=%0d c=%0d data=%h expected t=%0d d=%0d r=%0d l=%0d c=%0d data=%h",
                   e.tag, msg_type, msg_dest, msg_req, msg_line, msg_ackcnt, msg_data,
                   e.t, e.dest, e.rq, e.line, e.ack, e.data);
        end
      end
    end
  end

  task automatic do_req(input int rt, input int src, input int line,
                        input logic [DW-1:0] data, output int waits);
    @(negedge clk);
    req_valid = 1; req_type = 2'(rt); req_src = 2'(src);
    req_line = 3'(line); req_data = data;
    waits = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_wb(input int src, input int line, input logic [DW-1:0] data);
    @(negedge clk);
    wb_valid = 1; wb_src = 2'(src); wb_line = 3'(line); wb_data = data;
    @(posedge clk); #1;
    wb_valid = 0;
  endtask

  task automatic drain(input string tag);
    int guard;
    guard = 0;
    while (expq.size() != 0 && guard < 50) begin
      @(negedge clk); guard++;
    end
    check(expq.size() == 0, tag, "missing messages", expq.size(), 0);
    @(negedge clk); #1;
    check(msg_valid == 0, "R12", "idle message valid", int'(msg_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    rst_n = 0; req_valid = 0; req_type = 0; req_src = 0; req_line = 0; req_data = 0;
    wb_valid = 0; wb_src = 0; wb_line = 0; wb_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check(msg_valid == 0, "R1", "msg_valid after reset", int'(msg_valid), 0);
    check(req_ready == 1, "R1", "req_ready after reset", int'(req_ready), 1);

    // R1 / R2: fresh line reads give zero data, no count
    expect_msg(T_DATA, 1, 1, 0, 0, 0, 1, "R1");
    do_req(Q_RD, 1, 0, 0, w);
    expect_msg(T_DATA, 2, 2, 0, 0, 0, 1, "R2");
    do_req(Q_RD, 2, 0, 0, w);
    expect_msg(T_DATA, 3, 3, 0, 0, 0, 1, "R2");
    do_req(Q_RD, 3, 0, 0, w);
    drain("R2");

    // R4: write by a holder; invalidate caches 1 and 3
    expect_msg(T_DATA, 2, 2, 0, 0, 2, 1, "R4");
    expect_msg(T_INV, 1, 2, 0, 0, 0, 0, "R4");
    expect_msg(T_INV, 3, 2, 0, 0, 0, 0, "R4");
    do_req(Q_WR, 2, 0, 0, w);
    #1 check(req_ready == 0, "R4", "ready during inv burst", int'(req_ready), 0);
    drain("R4");

    // R6: ownership moves from 2 to 0
    expect_msg(T_FWR, 2, 0, 0, 0, 0, 0, "R6");
    do_req(Q_WR, 0, 0, 0, w);
    // R5/R6: read now forwarded to new owner 0
    expect_msg(T_FRD, 0, 1, 0, 0, 0, 0, "R6");
    do_req(Q_RD, 1, 0, 0, w);
    // R10 / R3: other line proceeds at once
    expect_msg(T_DATA, 3, 3, 1, 0, 0, 1, "R3");
    do_req(Q_WR, 3, 1, 0, w);
    check(w == 0, "R10", "wait cycles on other line", w, 0);
    drain("R10");

    // R5: held request to the waiting line
    expect_msg(T_DATA, 3, 3, 0, 32'hA5A5_0001, 0, 1, "R5");
    @(negedge clk);
    req_valid = 1; req_type = 2'(Q_RD); req_src = 2'd3; req_line = 3'd0; req_data = 0;
    for (int k = 0; k < 3; k++) begin
      #1 check(req_ready == 0, "R5", "ready while waiting", int'(req_ready), 0);
      @(negedge clk);
    end
    wb_valid = 1; wb_src = 2'd0; wb_line = 3'd0; wb_data = 32'hA5A5_0001;
    @(posedge clk); #1 wb_valid = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
    drain("R5");

    // R4: holders {0,1,3}; write by 1 invalidates 0 then 3
    expect_msg(T_DATA, 1, 1, 0, 32'hA5A5_0001, 2, 1, "R4");
    expect_msg(T_INV, 0, 1, 0, 0, 0, 0, "R4");
    expect_msg(T_INV, 3, 1, 0, 0, 0, 0, "R4");
    do_req(Q_WR, 1, 0, 0, w);
    drain("R4");

    // R7: owner eviction writes memory
    expect_msg(T_ACK, 1, 1, 0, 0, 0, 0, "R7");
    do_req(Q_EV, 1, 0, 32'h0000_1234, w);
    expect_msg(T_DATA, 2, 2, 0, 32'h0000_1234, 0, 1, "R7");
    do_req(Q_RD, 2, 0, 0, w);
    drain("R7");

    // R8: non-owner eviction on line 1 (owner 3)
    expect_msg(T_ACK, 0, 0, 1, 0, 0, 0, "R8");
    do_req(Q_EV, 0, 1, 32'hDEAD_BEEF, w);
    expect_msg(T_FRD, 3, 2, 1, 0, 0, 0, "R8");
    do_req(Q_RD, 2, 1, 0, w);
    drain("R8");
    // R11: write-back from wrong source ignored, then owner's accepted
    do_wb(1, 1, 32'h0000_0099);
    #1 check(req_ready == 0, "R11", "ready after foreign write-back", int'(req_ready), 0);
    do_wb(3, 1, 32'h0000_0077);

    // R9: line 1 holders {2,3}; both leave
    expect_msg(T_ACK, 2, 2, 1, 0, 0, 0, "R9");
    do_req(Q_DROP, 2, 1, 0, w);
    expect_msg(T_ACK, 3, 3, 1, 0, 0, 0, "R9");
    do_req(Q_DROP, 3, 1, 0, w);
    expect_msg(T_DATA, 0, 0, 1, 32'h0000_0077, 0, 1, "R9");
    do_req(Q_WR, 0, 1, 0, w);
    drain("R9");

    // R9: partial leave on line 2
    expect_msg(T_DATA, 0, 0, 2, 0, 0, 1, "R2");
    do_req(Q_RD, 0, 2, 0, w);
    expect_msg(T_DATA, 1, 1, 2, 0, 0, 1, "R2");
    do_req(Q_RD, 1, 2, 0, w);
    expect_msg(T_DATA, 2, 2, 2, 0, 0, 1, "R2");
    do_req(Q_RD, 2, 2, 0, w);
    expect_msg(T_ACK, 1, 1, 2, 0, 0, 0, "R9");
    do_req(Q_DROP, 1, 2, 0, w);
    expect_msg(T_DATA, 3, 3, 2, 0, 2, 1, "R9");
    expect_msg(T_INV, 0, 3, 2, 0, 0, 0, "R9");
    expect_msg(T_INV, 2, 3, 2, 0, 0, 0, "R9");
    do_req(Q_WR, 3, 2, 0, w);
    drain("R9");

    // R11: write-back to an idle line ignored
    do_wb(0, 5, 32'h0000_BEEF);
    expect_msg(T_DATA, 0, 0, 5, 0, 0, 1, "R11");
    do_req(Q_RD, 0, 5, 0, w);
    drain("R11");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule